// File: doc/BRIEF.md
# Transmit Buffer Descriptor Ring Engine

This block walks a circular table of transmit descriptors in a shared descriptor memory and sends the bytes of each referenced buffer to a downstream serializer. Each descriptor is 64 bits wide. The top 16 bits hold status and control, the next 16 bits hold the byte count, and the low 32 bits hold the buffer pointer, which may be odd or even. Descriptors sit 8 bytes apart, starting at a base address that is a multiple of 8.

Software fills a descriptor and sets its ready bit. The engine finds it by polling, streams the buffer one byte at a time over a valid/ready handshake, and writes the status halfword back. If the descriptor is in continuous mode, the ready bit stays set so the buffer goes out again on the next pass. Otherwise the ready bit is cleared, which hands the descriptor back to software.

Each completed buffer raises a sticky event flag. It also raises a sticky interrupt if the descriptor asked for one. Software clears both flags by pulsing a clear input.

Top module: `tbd_ring_engine`

## Requirements
- R1: The engine reads the descriptor at the current ring position and starts sending only when status bit 15 (ready) is set. If that bit is clear, it re-reads the same descriptor and never advances past it.
- R2: A ready descriptor with byte count N>0 produces exactly N output bytes, read in order from buffer addresses pointer, pointer+1, ..., pointer+N-1. Odd pointers are allowed.
- R3: The engine never writes the byte count or the pointer. Its only write to descriptor memory is the 16-bit status halfword (bits 63:48).
- R4: On closing a descriptor, the written status equals the fetched status with bit 15 cleared. The exception is when bit 9 (continuous mode) is set: then bit 15 stays set. All other status bits are preserved.
- R5: After closing a descriptor with status bit 13 (wrap) set, the next descriptor read is at the table base. Otherwise it is at the closed descriptor's address plus 8.
- R6: Every close sets evt_o. A close of a descriptor with status bit 12 (interrupt) set also sets irq_o. Both flags stay set until evt_clr_i is pulsed.
- R7: A ready descriptor with byte count zero is closed (written back, event raised) without sending any byte.
- R8: While tx_valid_o is high and tx_ready_i is low, tx_data_o and tx_valid_o hold. No buffer read is issued while a byte waits for its handshake.
- R9: When enable_i falls during a buffer, the byte already fetched is still delivered. No further byte is sent and the descriptor is not written back. On re-enable, the walk restarts at the table base.
- R10: After reset, tx_valid_o, evt_o, irq_o, desc_req_o and buf_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the ring walk |
| ring_base_i | input | ADDR_W | Byte address of the first descriptor, multiple of 8 |
| desc_req_o | output | 1 | Descriptor memory access strobe |
| desc_we_o | output | 1 | Access is a status halfword write |
| desc_addr_o | output | ADDR_W | Descriptor byte address |
| desc_wdata_o | output | 16 | Status halfword to write |
| desc_rdata_i | input | 64 | Descriptor read data, one cycle after the strobe |
| buf_req_o | output | 1 | Buffer byte read strobe |
| buf_addr_o | output | 32 | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer byte, one cycle after the strobe |
| tx_data_o | output | 8 | Byte to the serializer |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_ready_i | input | 1 | Serializer accepts the byte |
| evt_clr_i | input | 1 | Clear the event and interrupt flags |
| evt_o | output | 1 | Sticky buffer-complete event |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The bench uses the default ADDR_W of 16 and a descriptor memory model of 32 slots, decoded from address bits 7:3. This lets ring bases move across the table between rounds. Random rings of one to four entries, with byte counts from zero to six and random pointers, cover several cases: single-entry rings that wrap onto themselves, zero-length closes, and odd buffer addresses. Random backpressure on tx_ready_i exercises the hold behaviour. Directed runs cover the stall on an unready head descriptor, continuous-mode retention, and disabling in the middle of a 20-byte buffer.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned PTR_W     = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned DESC_BYTES = 8;
  // status bit positions (bit 15 = MSB)
  localparam int unsigned ST_READY  = 15;
  localparam int unsigned ST_WRAP   = 13;
  localparam int unsigned ST_INTR   = 12;
  localparam int unsigned ST_CONT   = 9;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic [LEN_W-1:0]  len;
    logic [PTR_W-1:0]  ptr;
  } tbd_desc_t;

  localparam int unsigned DESC_W = $bits(tbd_desc_t);

  typedef enum logic [2:0] {C_IDLE, C_FETCH, C_WAIT, C_SEND, C_CLOSE} ctrl_st_e;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_CAP, S_HOLD} strm_st_e;
endpackage

// File: rtl/tbd_byte_stream.sv
module tbd_byte_stream
  import tbd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              abort_i,
  output logic              done_o,
  output logic              halt_o,
  output logic              buf_req_o,
  output logic [PTR_W-1:0]  buf_addr_o,
  input  logic [BYTE_W-1:0] buf_rdata_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  strm_st_e          st_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              hs, last;

  assign hs   = (st_q == S_HOLD) && tx_ready_i;
  assign last = (cnt_q == LEN_W'(1));

  assign done_o     = hs && last;
  assign halt_o     = (hs && !last && abort_i) || ((st_q == S_REQ) && abort_i);
  assign buf_req_o  = (st_q == S_REQ) && !abort_i;
  assign buf_addr_o = addr_q;
  assign tx_data_o  = data_q;
  assign tx_valid_o = (st_q == S_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          cnt_q  <= len_i;
          addr_q <= ptr_i;
          st_q   <= S_REQ;
        end
        S_REQ: st_q <= abort_i ? S_IDLE : S_CAP;
        S_CAP: begin
          data_q <= buf_rdata_i;
          addr_q <= addr_q + PTR_W'(1);
          st_q   <= S_HOLD;
        end
        S_HOLD: if (tx_ready_i) begin
          cnt_q <= cnt_q - LEN_W'(1);
          st_q  <= (last || abort_i) ? S_IDLE : S_REQ;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbd_ring_ctrl.sv
module tbd_ring_ctrl
  import tbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  output logic              desc_req_o,
  output logic              desc_we_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [STAT_W-1:0] desc_wdata_o,
  input  logic [DESC_W-1:0] desc_rdata_i,
  output logic              start_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              abort_o,
  input  logic              done_i,
  input  logic              halt_i,
  output logic              close_o,
  output logic              close_irq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  ctrl_st_e          st_q;
  logic [ADDR_W-1:0] ptr_q;
  tbd_desc_t         desc_q, rd_desc;
  logic              rd_ready, rd_empty;
  logic [STAT_W-1:0] wb_stat;

  assign rd_desc  = tbd_desc_t'(desc_rdata_i);
  assign rd_ready = rd_desc.stat[ST_READY];
  assign rd_empty = (rd_desc.len == '0);

  always_comb begin
    wb_stat = desc_q.stat;
    if (!desc_q.stat[ST_CONT]) wb_stat[ST_READY] = 1'b0;
  end

  assign desc_req_o   = (st_q == C_FETCH) || (st_q == C_CLOSE);
  assign desc_we_o    = (st_q == C_CLOSE);
  assign desc_addr_o  = ptr_q;
  assign desc_wdata_o = wb_stat;

  assign start_o     = (st_q == C_WAIT) && enable_i && rd_ready && !rd_empty;
  assign len_o       = rd_desc.len;
  assign ptr_o       = rd_desc.ptr;
  assign abort_o     = !enable_i;
  assign close_o     = (st_q == C_CLOSE);
  assign close_irq_o = desc_q.stat[ST_INTR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      ptr_q  <= '0;
      desc_q <= '0;
    end else begin
      unique case (st_q)
        C_IDLE: begin
          ptr_q <= ring_base_i;
          if (enable_i) st_q <= C_FETCH;
        end
        C_FETCH: st_q <= enable_i ? C_WAIT : C_IDLE;
        C_WAIT: begin
          desc_q <= rd_desc;
          if (!enable_i)     st_q <= C_IDLE;
          else if (!rd_ready) st_q <= C_FETCH;   // stall on this entry
          else if (rd_empty)  st_q <= C_CLOSE;
          else                st_q <= C_SEND;
        end
        C_SEND: begin
          if (done_i)      st_q <= C_CLOSE;
          else if (halt_i) st_q <= C_IDLE;
        end
        C_CLOSE: begin
          ptr_q <= desc_q.stat[ST_WRAP] ? ring_base_i : ptr_q + STEP;
          st_q  <= enable_i ? C_FETCH : C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbd_event_flags.sv
module tbd_event_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic evt_o,
  output logic irq_o
);
  logic evt_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (set_i)      evt_q <= 1'b1;
      else if (clr_i) evt_q <= 1'b0;
      if (set_i && irq_en_i) irq_q <= 1'b1;
      else if (clr_i)        irq_q <= 1'b0;
    end
  end

  assign evt_o = evt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tbd_ring_engine.sv
module tbd_ring_engine
  import tbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  output logic              desc_req_o,
  output logic              desc_we_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [15:0]       desc_wdata_o,
  input  logic [63:0]       desc_rdata_i,
  output logic              buf_req_o,
  output logic [31:0]       buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              evt_clr_i,
  output logic              evt_o,
  output logic              irq_o
);
  logic             start, abort, done, halt, close, close_irq;
  logic [LEN_W-1:0] len;
  logic [PTR_W-1:0] ptr;

  tbd_ring_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .ring_base_i  (ring_base_i),
    .desc_req_o   (desc_req_o),
    .desc_we_o    (desc_we_o),
    .desc_addr_o  (desc_addr_o),
    .desc_wdata_o (desc_wdata_o),
    .desc_rdata_i (desc_rdata_i),
    .start_o      (start),
    .len_o        (len),
    .ptr_o        (ptr),
    .abort_o      (abort),
    .done_i       (done),
    .halt_i       (halt),
    .close_o      (close),
    .close_irq_o  (close_irq)
  );

  tbd_byte_stream i_stream (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .len_i       (len),
    .ptr_i       (ptr),
    .abort_i     (abort),
    .done_o      (done),
    .halt_o      (halt),
    .buf_req_o   (buf_req_o),
    .buf_addr_o  (buf_addr_o),
    .buf_rdata_i (buf_rdata_i),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i)
  );

  tbd_event_flags i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (close),
    .irq_en_i (close_irq),
    .clr_i    (evt_clr_i),
    .evt_o    (evt_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/tbd_ring_engine_chk.sv
module tbd_ring_engine_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              desc_req_o,
  input logic              desc_we_o,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic [15:0]       desc_wdata_o,
  input logic              buf_req_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              evt_o,
  input logic              irq_o
);
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R8
  AST_NO_READ_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !buf_req_o); // R8
  AST_DESC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o |-> desc_addr_o[2:0] == 3'b000); // R5
  AST_RELEASE_OWNERSHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o && desc_we_o && !desc_wdata_o[9] |-> !desc_wdata_o[15]); // R4
  AST_CONT_KEEPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o && desc_we_o && desc_wdata_o[9] |-> desc_wdata_o[15]); // R4
  AST_IRQ_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_o); // R6
  AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_req_o && buf_req_o)); // R1
endmodule

bind tbd_ring_engine tbd_ring_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .desc_req_o   (desc_req_o),
  .desc_we_o    (desc_we_o),
  .desc_addr_o  (desc_addr_o),
  .desc_wdata_o (desc_wdata_o),
  .buf_req_o    (buf_req_o),
  .tx_data_o    (tx_data_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .evt_o        (evt_o),
  .irq_o        (irq_o)
);

// File: tb/test_tbd_ring_engine.sv
`timescale 1ns/1ps
module test_tbd_ring_engine;
  localparam int unsigned ADDR_W = 16;
  localparam logic [15:0] B_R = 16'h8000, B_W = 16'h2000, B_I = 16'h1000, B_CM = 16'h0200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [ADDR_W-1:0] ring_base = '0;
  logic              desc_req, desc_we, buf_req, tx_valid, evt, irq;
  logic [ADDR_W-1:0] desc_addr;
  logic [15:0]       desc_wdata;
  logic [63:0]       desc_rdata = '0;
  logic [31:0]       buf_addr;
  logic [7:0]        buf_rdata = '0;
  logic [7:0]        tx_data;
  logic              tx_ready = 1'b0;
  logic              evt_clr = 1'b0;

  logic [63:0] dmem [0:31];
  logic        h_we = 1'b0;
  logic [4:0]  h_idx = '0;
  logic [63:0] h_val = '0;
  int          rdy_mode = 0;

  logic [7:0] exp_mem [0:1023];
  int exp_wr = 0, mon_rd = 0;
  int checks = 0, errors = 0, mon_checks = 0, mon_errs = 0;

  always #2 clk = ~clk;

  tbd_ring_engine #(.ADDR_W(ADDR_W)) i_tbd_ring_engine (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ring_base_i(ring_base),
    .desc_req_o(desc_req), .desc_we_o(desc_we), .desc_addr_o(desc_addr),
    .desc_wdata_o(desc_wdata), .desc_rdata_i(desc_rdata),
    .buf_req_o(buf_req), .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .evt_clr_i(evt_clr), .evt_o(evt), .irq_o(irq)
  );

  function automatic logic [7:0] buf_byte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  // memory model: one-cycle read latency, status halfword writes
  initial begin
    for (int i = 0; i < 32; i++) dmem[i] = '0;
    forever begin
      @(posedge clk);
      if (desc_req && !desc_we) desc_rdata <= dmem[desc_addr[7:3]];
      if (desc_req && desc_we)  dmem[desc_addr[7:3]][63:48] <= desc_wdata;
      if (h_we)                 dmem[h_idx] <= h_val;
      if (buf_req)              buf_rdata <= buf_byte(buf_addr);
    end
  end

  initial forever begin
    @(posedge clk); #1;
    case (rdy_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= ($urandom % 4) != 0;
      default: tx_ready <= 1'b0;
    endcase
  end

  // output monitor
  initial begin
    logic       held = 1'b0;
    logic [7:0] held_d = '0;
    forever begin
      @(negedge clk);
      if (tx_valid && held) begin
        mon_checks++;
        if (tx_data !== held_d) begin
          mon_errs++;
          $display("FAIL R8 held byte act=%0h exp=%0h", tx_data, held_d);
        end
      end
      if (held && !tx_valid) begin
        mon_checks++; mon_errs++;
        $display("FAIL R8 valid dropped act=0 exp=1");
      end
      if (tx_valid && tx_ready) begin
        mon_checks++;
        if (mon_rd >= exp_wr) begin
          mon_errs++;
          $display("FAIL R2 unexpected byte act=%0h exp=none", tx_data);
        end else begin
          if (tx_data !== exp_mem[mon_rd]) begin
            mon_errs++;
            $display("FAIL R2 byte %0d act=%0h exp=%0h", mon_rd, tx_data, exp_mem[mon_rd]);
          end
          mon_rd++;
        end
      end
      held   = tx_valid && !tx_ready;
      held_d = tx_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errs + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_put(input int idx, input logic [15:0] st, input logic [15:0] ln, input logic [31:0] p);
    @(posedge clk); #1;
    h_we = 1'b1; h_idx = 5'(idx); h_val = {st, ln, p};
    @(posedge clk); #1;
    h_we = 1'b0;
  endtask

  task automatic push_bytes(input logic [31:0] p, input int n);
    for (int j = 0; j < n; j++) begin
      exp_mem[exp_wr % 1024] = buf_byte(p + 32'(j));
      exp_wr++;
    end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 4000 && mon_rd != exp_wr; i++) tick(1);
    tick(40);
    chk(mon_rd == exp_wr, tag, 64'(mon_rd), 64'(exp_wr));
  endtask

  task automatic clear_flags();
    @(posedge clk); #1; evt_clr = 1'b1;
    @(posedge clk); #1; evt_clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    @(negedge clk);
    // R10 reset state
    chk(!tx_valid && !evt && !irq && !desc_req && !buf_req, "R10 outputs after reset",
        {59'd0, tx_valid, evt, irq, desc_req, buf_req}, 64'd0);

    // directed ring at 0x40: stall, continuous mode, zero length
    ring_base = 16'h0040;
    host_put(8,  B_R | B_I,  16'd3, 32'h0000_1001);
    host_put(9,  B_R | B_CM, 16'd2, 32'h0000_2000);
    host_put(10, B_R | B_W,  16'd0, 32'h0000_3000);
    push_bytes(32'h1001, 3);
    push_bytes(32'h2000, 2);
    rdy_mode = 1;
    enable = 1'b1;
    drain("R2 directed byte count");
    chk(dmem[8][63:48]  == B_I, "R4 d0 ready released", dmem[8][63:48], B_I);
    chk(dmem[9][63:48]  == (B_R | B_CM), "R4 continuous keeps ready", dmem[9][63:48], B_R | B_CM);
    chk(dmem[10][63:48] == B_W, "R7 zero length closed", dmem[10][63:48], B_W);
    chk(dmem[8][47:32]  == 16'd3, "R3 length untouched", dmem[8][47:32], 16'd3);
    chk(evt && irq, "R6 flags set", {evt, irq}, 2'b11);
    tick(60);
    chk(mon_rd == exp_wr, "R1 stall on unready head", 64'(mon_rd), 64'(exp_wr));
    clear_flags();
    @(negedge clk);
    chk(!evt && !irq, "R6 flags cleared", {evt, irq}, 2'b00);
    // re-arm head: d0 then d1 (continuous) again, stall at d2
    host_put(8, B_R | B_I, 16'd3, 32'h0000_1001);
    push_bytes(32'h1001, 3);
    push_bytes(32'h2000, 2);
    drain("R5 wrap and second pass");
    chk(dmem[9][63:48] == (B_R | B_CM), "R4 continuous retained", dmem[9][63:48], B_R | B_CM);
    chk(dmem[10][63:48] == B_W, "R1 cleared entry not resent", dmem[10][63:48], B_W);

    // disable in the middle of a long buffer
    enable = 1'b0;
    tick(4);
    clear_flags();
    ring_base = 16'h0000;
    host_put(0, B_R | B_W, 16'd20, 32'h0000_0300);
    rdy_mode = 2;
    push_bytes(32'h300, 1);
    enable = 1'b1;
    for (int i = 0; i < 200 && !tx_valid; i++) tick(1);
    enable = 1'b0;
    tick(4);
    @(negedge clk);
    chk(tx_valid, "R9 current byte still offered", 64'(tx_valid), 64'd1);
    rdy_mode = 0;
    drain("R9 only current byte");
    @(negedge clk);
    chk(!tx_valid && !evt, "R9 stopped without close", {tx_valid, evt}, 2'b00);
    chk(dmem[0][63:48] == (B_R | B_W), "R9 no write-back", dmem[0][63:48], B_R | B_W);
    push_bytes(32'h300, 20);
    enable = 1'b1;
    drain("R9 restart from base");
    chk(dmem[0][63:48] == B_W, "R5 single entry wraps", dmem[0][63:48], B_W);

    // random rings
    for (int r = 0; r < 10; r++) begin
      int n, base;
      bit any_i;
      logic [15:0] st [4];
      logic [15:0] ln [4];
      logic [31:0] pt [4];
      enable = 1'b0;
      tick(4);
      clear_flags();
      n = 1 + int'($urandom % 4);
      base = int'($urandom % 24);
      ring_base = ADDR_W'(base * 8);
      any_i = 1'b0;
      for (int k = 0; k < n; k++) begin
        ln[k] = 16'($urandom % 7);
        pt[k] = $urandom;
        st[k] = B_R | 16'($urandom % 256);
        if ($urandom % 2) st[k] = st[k] | B_I;
        if (k == n - 1) st[k] = st[k] | B_W;
        if (ln[k] != 0 && st[k][12]) any_i = 1'b1;
        if (ln[k] == 0 && st[k][12]) any_i = 1'b1;
        host_put(base + k, st[k], ln[k], pt[k]);
        push_bytes(pt[k], int'(ln[k]));
      end
      rdy_mode = (r % 2 == 0) ? 1 : 0;
      enable = 1'b1;
      drain("R2 random ring bytes");
      for (int k = 0; k < n; k++) begin
        chk(dmem[base + k][63:48] == (st[k] & ~B_R), "R4 random write-back",
            dmem[base + k][63:48], st[k] & ~B_R);
        chk(dmem[base + k][47:0] == {ln[k], pt[k]}, "R3 random length and pointer",
            dmem[base + k][47:0], {ln[k], pt[k]});
      end
      @(negedge clk);
      chk(evt && (irq == any_i), "R6 random flags", {evt, irq}, {1'b1, any_i});
    end

    enable = 1'b0;
    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errs);
    $finish;
  end
endmodule